// File: doc/BRIEF.md
# Prioritized Interrupt Status and Enable Unit

This unit gathers sixteen interrupt sources into one status register. Seven of them are prioritized backplane interrupt levels. The rest are special sources: bus ownership, DMA completion, error reports, failure lines and software interrupts. A separate enable register gates each source in two places. A source can latch its status bit only while it is enabled, and a latched bit drives its routed output line only while it is enabled. Each source has a 3-bit routing field that picks one of eight output lines. The fields are held in two map registers.

Software reads the status, enable, map and per-level vector registers. It clears status bits by writing ones to them. While it services a level, it masks that level and all lower levels by rewriting the enable register. A masked status bit stays set, so the same level is not acknowledged a second time until software clears it. The acknowledge cycle on the backplane is represented by a vector and an error flag that arrive with each level request. The unit captures them when the level's status bit becomes set.

The unit also reports the highest enabled, pending level, so a handler can select the level to service without scanning the status register.

Top module: `irq_prio_unit`

## Requirements
- R1: A status bit becomes set at the clock edge where its request input is high and its enable bit is already set. A request arriving while the enable bit is clear leaves the status bit clear.
- R2: An output line is high exactly when some source routed to it has both its status and enable bits set. Clearing an enable bit removes that source from the outputs but leaves its status bit set.
- R3: Request input i maps to status bit i. Bit 0 is bus ownership. Bits 1 to 7 are backplane levels 1 to 7. Bit 8 is DMA done. Bits 9 to 15 are the other special sources.
- R4: A write to word address 0 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. An enabled request in the same cycle as the clear wins, and its bit stays set.
- R5: Level L has a read-only vector register at word address 3+L, so level 1 is at address 4 and level 7 at address 10. Bits 7:0 hold the vector and bit 8 holds the error flag. Both are captured only when the level's status bit goes from clear to set, and they hold while the bit stays set.
- R6: top_level is the number of the highest level whose status and enable bits are both set. Level 7 has the highest priority. The value is 0 when no such level exists, and special sources never affect it.
- R7: The map at word address 2 routes sources 0 to 7, and the map at word address 3 routes sources 8 to 15. Source k uses bits [4(k mod 8)+2 : 4(k mod 8)] of its map, and the field value is the number of the output line.
- R8: Reset clears the status, enable, map and vector registers. After reset every output is low, top_level is 0 and every register reads 0.
- R9: Address 0 reads the status register and address 1 reads the enable register, both in bits 15:0. Map reads return only the 3-bit fields, with bit 3 of each nibble reading 0. Addresses 11 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 16 | Request per source, sampled each clock |
| lvl_vec | input | 7*VEC_W | Vector for each level, level 1 in the low byte |
| lvl_err | input | 7 | Acknowledge error flag per level, level 1 in bit 0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| irq_out | output | NOUT | Routed interrupt output lines |
| top_level | output | 3 | Highest enabled pending level, 0 when none |

## Verification
Requests and register writes take effect at the next clock edge. The outputs and read data are combinational from the registers, so every result is due one edge after the stimulus. The bench drives inputs on the falling edge. It updates its reference model on the rising edge and compares outputs on the next falling edge, where they have settled. Read data is sampled a short delay after rd_addr changes, and no edge falls within that delay. Directed cases check exact values for the gating, masking, write-one-to-clear race and vector hold. A long random phase compares every cycle against the model.

// File: rtl/irq_prio_unit.sv
module irq_prio_unit #(
  parameter int VEC_W  = 8,
  parameter int NOUT   = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         src_req,
  input  logic [7*VEC_W-1:0]  lvl_vec,
  input  logic [6:0]          lvl_err,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NOUT-1:0]     irq_out,
  output logic [2:0]          top_level
);
  localparam int NSRC  = 16;
  localparam int NLVL  = 7;
  localparam int FPM   = 8;
  localparam int FLD_W = 4;
  localparam int SEL_W = $clog2(NOUT);
  localparam int VBASE = 4;

  logic [NSRC-1:0]  status_q, en_q;
  logic [SEL_W-1:0] sel_q [NSRC];
  logic [VEC_W-1:0] vec_q [NLVL];
  logic [NLVL-1:0]  err_q;

  wire wr_st   = wr_en && (wr_addr == ADDR_W'(0));
  wire wr_en_r = wr_en && (wr_addr == ADDR_W'(1));
  wire wr_m0   = wr_en && (wr_addr == ADDR_W'(2));
  wire wr_m1   = wr_en && (wr_addr == ADDR_W'(3));

  wire [NSRC-1:0] clr_bits = wr_st ? wr_data[NSRC-1:0] : '0;
  wire [NSRC-1:0] set_bits = src_req & en_q;
  wire [NSRC-1:0] kept     = status_q & ~clr_bits;
  wire [NSRC-1:0] load     = set_bits & ~kept;
  wire [NSRC-1:0] pending  = status_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      en_q     <= '0;
    end else begin
      status_q <= kept | set_bits;
      if (wr_en_r) en_q <= wr_data[NSRC-1:0];
    end
  end

  for (genvar i = 0; i < FPM; i++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i]     <= '0;
        sel_q[FPM+i] <= '0;
      end else begin
        if (wr_m0) sel_q[i]     <= wr_data[FLD_W*i +: SEL_W];
        if (wr_m1) sel_q[FPM+i] <= wr_data[FLD_W*i +: SEL_W];
      end
    end
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_vec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q[l] <= '0;
        err_q[l] <= 1'b0;
      end else if (load[l+1]) begin
        vec_q[l] <= lvl_vec[VEC_W*l +: VEC_W];
        err_q[l] <= lvl_err[l];
      end
    end
  end

  always_comb begin
    irq_out = '0;
    for (int i = 0; i < NSRC; i++)
      if (pending[i]) irq_out[sel_q[i]] = 1'b1;
  end

  always_comb begin
    top_level = '0;
    for (int l = 1; l <= NLVL; l++)
      if (pending[l]) top_level = 3'(l);
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(0): rd_data[NSRC-1:0] = status_q;
      ADDR_W'(1): rd_data[NSRC-1:0] = en_q;
      ADDR_W'(2): for (int i = 0; i < FPM; i++) rd_data[FLD_W*i +: SEL_W] = sel_q[i];
      ADDR_W'(3): for (int i = 0; i < FPM; i++) rd_data[FLD_W*i +: SEL_W] = sel_q[FPM+i];
      default: begin
        for (int l = 0; l < NLVL; l++)
          if (rd_addr == ADDR_W'(VBASE + l)) begin
            rd_data[VEC_W-1:0] = vec_q[l];
            rd_data[VEC_W]     = err_q[l];
          end
      end
    endcase
  end

  p_gate_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_q)) == '0));

  p_out_has_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> ((status_q & en_q) != '0));

  p_mask_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_st) |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st |=> ((status_q & $past(wr_data[NSRC-1:0] & ~(src_req & en_q))) == '0));

  p_top_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (top_level != 3'd0) |-> (status_q[top_level] && en_q[top_level]));

  p_vec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[7] && !(wr_st && wr_data[7])) |=> $stable(vec_q[6]));
endmodule

// File: tb/irq_prio_unit_test.sv
`timescale 1ns/1ps
module irq_prio_unit_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] src_req = '0;
  logic [55:0] lvl_vec = '0;
  logic [6:0]  lvl_err = '0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  irq_out;
  logic [2:0]  top_level;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_prio_unit uut (.clk, .rst_n, .src_req, .lvl_vec, .lvl_err, .wr_en, .wr_addr,
                     .wr_data, .rd_addr, .rd_data, .irq_out, .top_level);

  logic [15:0] m_st, m_en;
  logic [31:0] m_map0, m_map1;
  logic [7:0]  m_vec [7];
  logic [6:0]  m_err;

  always @(posedge clk or negedge rst_n) begin : model
    logic [15:0] clr, set, kept;
    if (!rst_n) begin
      m_st <= 0; m_en <= 0; m_map0 <= 0; m_map1 <= 0; m_err <= 0;
      for (int l = 0; l < 7; l++) m_vec[l] <= 0;
    end else begin
      clr  = (wr_en && wr_addr == 0) ? wr_data[15:0] : 16'h0;
      set  = src_req & m_en;
      kept = m_st & ~clr;
      m_st <= kept | set;
      for (int l = 0; l < 7; l++)
        if (set[l+1] && !kept[l+1]) begin
          m_vec[l] <= lvl_vec[8*l +: 8];
          m_err[l] <= lvl_err[l];
        end
      if (wr_en && wr_addr == 1) m_en   <= wr_data[15:0];
      if (wr_en && wr_addr == 2) m_map0 <= wr_data & 32'h7777_7777;
      if (wr_en && wr_addr == 3) m_map1 <= wr_data & 32'h7777_7777;
    end
  end

  function automatic logic [7:0] exp_irq();
    logic [7:0] r = 0;
    for (int i = 0; i < 16; i++)
      if (m_st[i] && m_en[i]) r[((i < 8 ? m_map0 : m_map1) >> (4*(i%8))) & 7] = 1'b1;
    return r;
  endfunction

  function automatic logic [2:0] exp_top();
    logic [2:0] t = 0;
    for (int l = 1; l <= 7; l++) if (m_st[l] && m_en[l]) t = 3'(l);
    return t;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      0: return {16'h0, m_st};
      1: return {16'h0, m_en};
      2: return m_map0;
      3: return m_map1;
      default: return (a >= 4 && a <= 10) ? {23'h0, m_err[a-4], m_vec[a-4]} : 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic cmp_all(input string tag);
    logic [31:0] d;
    chk({tag, " R2 R7 irq_out"}, 32'(irq_out), 32'(exp_irq()));
    chk({tag, " R6 top_level"}, 32'(top_level), 32'(exp_top()));
    rd(4'($urandom_range(0, 15)), d);
    chk({tag, " R9 R5 read"}, d, exp_rd(rd_addr));
  endtask

  task automatic step(input logic [15:0] req, input logic we, input logic [3:0] a,
                      input logic [31:0] dat);
    src_req = req; wr_en = we; wr_addr = a; wr_data = dat;
    @(posedge clk); @(negedge clk);
    src_req = 0; wr_en = 0;
    cmp_all("model");
  endtask

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 irq_out after reset", 32'(irq_out), 0);
    chk("R8 top_level after reset", 32'(top_level), 0);
    for (int a = 0; a < 16; a++) begin rd(4'(a), d); chk("R8 R9 register after reset", d, 0); end

    step(16'hFFFF, 0, 0, 0);
    rd(0, d); chk("R1 disabled request ignored", d, 0);
    chk("R1 no output", 32'(irq_out), 0);

    step(0, 1, 1, 32'h0000_FFFF);
    lvl_vec = '0; lvl_vec[8*2 +: 8] = 8'h33; lvl_vec[8*6 +: 8] = 8'h77; lvl_err = 7'b100_0000;
    step(16'h0188, 0, 0, 0);
    rd(0, d); chk("R3 status bits 3 7 8", d, 32'h0188);
    chk("R6 level 7 wins", 32'(top_level), 7);
    chk("R7 default route line 0", 32'(irq_out), 32'h01);
    rd(6, d); chk("R5 level 3 vector", d, 32'h033);
    rd(10, d); chk("R5 level 7 vector and error", d, 32'h177);

    lvl_vec[8*2 +: 8] = 8'h99; lvl_err = 0;
    step(16'h0008, 0, 0, 0);
    rd(6, d); chk("R5 vector held while set", d, 32'h033);

    step(0, 1, 2, 32'hD000_0000);
    step(0, 1, 3, 32'h0000_000A);
    chk("R7 routed lines", 32'(irq_out), 32'h25);
    rd(2, d); chk("R9 map field bits only", d, 32'h5000_0000);

    step(0, 1, 1, 32'h0000_FF7F);
    rd(0, d); chk("R2 masked status kept", d, 32'h0188);
    chk("R2 masked output", 32'(irq_out), 32'h05);
    chk("R6 masked level skipped", 32'(top_level), 3);

    step(0, 1, 0, 32'h0000_0100);
    rd(0, d); chk("R4 w1c single bit", d, 32'h0088);
    step(16'h0008, 1, 0, 32'h0000_0008);
    rd(0, d); chk("R4 request beats clear", d, 32'h0088);
    rd(6, d); chk("R5 reload after clear", d, 32'h099);
    step(0, 1, 0, 32'h0000_FFFF);
    rd(0, d); chk("R4 clear all", d, 0);
    chk("R6 none pending", 32'(top_level), 0);
    rd(12, d); chk("R9 unused address", d, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [15:0] rq = 16'($urandom) & 16'($urandom);
      logic we = ($urandom_range(0, 9) < 3);
      lvl_vec = {$urandom, $urandom};
      lvl_err = 7'($urandom);
      step(rq, we, 4'($urandom_range(0, 4)), $urandom);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule